// File: doc/BRIEF.md
# Dual-Sensor Serial Acquisition Controller

This block is a serial-bus master for two sensors that share one serial clock line, one control-word line toward the devices and one data line back from them. One device is a 12-bit, 8-channel converter. The other is a 10-bit temperature sensor. The host raises a one-cycle request pulse, picks the device with a select input and, for the converter, supplies a 3-bit channel number. The block runs every frame the device needs and pulses a completion strobe once, when fresh data sits on the result bus.

The converter protocol is hidden from the host. After reset the block runs two throw-away frames to the converter on its own. A converter request sends a control-word write frame only when the channel differs from the one last programmed, and then sends the read frame. Only the read frame, or the single temperature frame, produces the completion strobe. Each frame is 16 serial-clock periods long. The serial clock comes from the system clock through a parameterised divider and rests high between frames.

Top module: `sacq_top`

## Requirements
- R1: While the reset input is low, the reset output is low, the serial clock is high, the converter select is high (inactive), the temperature enable is low, the completion strobe is low and all result buses are zero. The reset output is high from the first clock edge after reset is released.
- R2: After reset, two frames go to the converter before any request is served. During those frames the control line stays high for all 16 bits, and they produce no completion strobe.
- R3: A frame is 16 serial-clock periods, each 2*DIV_HALF system clocks long. The serial clock is high whenever no device is selected. The control line changes only when the serial clock falls. Bits are sent most significant first, and incoming bits are sampled when the serial clock rises.
- R4: A request with the select input high runs exactly one frame with only the temperature enable asserted. A request with it low asserts only the converter select. The two selects are never active together.
- R5: A converter request whose channel differs from the last programmed channel runs a write frame and then a read frame. The write word has bit 15 set, the channel in bits 12:10, and the remaining bits from the control base (default 0x0031). The read word is all zero.
- R6: A converter request on the same channel as the last programmed one runs only the read frame.
- R7: The first converter request after reset always includes the write frame, whatever channel it names.
- R8: The completion strobe is one clock wide. It fires exactly once per request, after the read frame or the temperature frame, and never after throw-away or write frames.
- R9: At the end of a converter read frame, incoming bits 14:12 appear on the channel output and bits 11:0 on the converter data bus. At the end of a temperature frame, bits 14:5 appear on the temperature bus. The other device's bus is unchanged.
- R10: A request pulse that arrives while frames or their gaps are in progress, including the startup frames, is ignored.
- R11: Between frames, both selects stay inactive for at least one serial-clock period (2*DIV_HALF system clocks).
- R12: The channel input is ignored for temperature requests. It does not alter the remembered converter channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | One-cycle request pulse |
| sel_temp | input | 1 | 1 = temperature sensor, 0 = converter |
| ch_sel | input | 3 | Requested converter channel |
| sdo | input | 1 | Serial data returned by the devices |
| sclk | output | 1 | Serial clock, high when idle |
| rst_out_n | output | 1 | Reset output, low while in reset |
| sdi | output | 1 | Serial control word toward the devices |
| adc_cs_n | output | 1 | Converter select, active low |
| tmp_ce | output | 1 | Temperature sensor enable, active high |
| done | output | 1 | Completion strobe |
| adc_data | output | 12 | Converter result |
| adc_ch | output | 3 | Channel that produced the converter result |
| temp_data | output | 10 | Temperature result |

## Verification
A new request and the completion of the previous one can land on the same clock. The strobe fires on the clock that the final frame ends and the inter-frame gap begins. The bench raises a new request on exactly the clock where it sees the strobe high. The reference model, which treats the controller as busy through the gap, expects no further frame and no second strobe, and the frame record and strobe count are compared against that expectation. A request raised during the startup frames is judged in the same way.

// File: rtl/sacq_pkg.sv
// Shared types for the serial acquisition controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sacq_pkg;

    // Kind of frame on the serial bus.
    typedef enum logic [1:0] {
        KIND_DUMMY = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_READ  = 2'd2,
        KIND_TEMP  = 2'd3
    } frame_kind_t;

    // Sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sacq_clkdiv.sv
// Half-period timer for the serial clock.
// Produces a one-cycle tick at the last system clock of every half
// serial-clock period while 'run' is high. Assumes DIV_HALF >= 1.
module sacq_clkdiv #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    assign half_tick = run && (cnt == LAST);

    // Count system clocks within the current half period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (half_tick)  cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // R3: the half-period counter never passes its limit.
    assert_half_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/sacq_shifter.sv
// One serial frame: drives the serial clock, shifts the control word out
// MSB first (changing on the falling edge), samples the return line on the
// rising edge. Only the last FRAME_BITS-1 samples are kept; the leading
// returned bit carries no information.
// Assumes 'start' is only raised while no frame is active.
module sacq_shifter #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  half_tick,
    input  logic                  sdo,
    output logic                  sclk,
    output logic                  sdi,
    output logic [FRAME_BITS-2:0] rx_word,
    output logic                  frame_end
);
    localparam int HALVES = 2 * FRAME_BITS;
    localparam int HW     = $clog2(HALVES);
    localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

    logic                  active;
    logic [HW-1:0]         half_idx;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [FRAME_BITS-2:0] rx_sh;
    logic                  sclk_q;

    assign frame_end = active && half_tick && (half_idx == LAST_HALF);
    assign sclk      = sclk_q;
    assign sdi       = active ? tx_sh[FRAME_BITS-1] : 1'b1;
    assign rx_word   = rx_sh;

    // Walk the 2*FRAME_BITS half periods of a frame.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            half_idx <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            sclk_q   <= 1'b1;
        end else if (start) begin
            active   <= 1'b1;
            half_idx <= '0;
            tx_sh    <= tx_word;
            sclk_q   <= 1'b0;
        end else if (active && half_tick) begin
            if (frame_end) begin
                active   <= 1'b0;
                half_idx <= '0;
            end else if (!half_idx[0]) begin
                sclk_q   <= 1'b1;
                rx_sh    <= {rx_sh[FRAME_BITS-3:0], sdo};
                half_idx <= half_idx + 1'b1;
            end else begin
                sclk_q   <= 1'b0;
                tx_sh    <= {tx_sh[FRAME_BITS-2:0], 1'b1};
                half_idx <= half_idx + 1'b1;
            end
        end
    end

    // R3: serial clock rests high outside a frame.
    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sclk_q);

    // R3: inside a frame the control line moves only with a falling clock.
    assert_sdi_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$fell(sclk_q)) |-> $stable(sdi));

endmodule

// File: rtl/sacq_seq.sv
// Transaction sequencer: runs the startup throw-away frames, decides whether
// a converter request needs a control write, chains write and read, keeps
// the inter-frame gap, latches results and raises the completion strobe.
// Assumes the shifter reports frame_end for exactly one cycle per frame.
module sacq_seq
    import sacq_pkg::*;
#(
    parameter int                  FRAME_BITS   = 16,
    parameter int                  CH_W         = 3,
    parameter int                  ADC_W        = 12,
    parameter int                  TEMP_W       = 10,
    parameter int                  DUMMY_FRAMES = 2,
    parameter int                  CH_LSB       = 10,
    parameter logic [FRAME_BITS-1:0] CTRL_BASE  = 16'h0031,
    parameter logic [FRAME_BITS-1:0] READ_WORD  = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  sel_temp,
    input  logic [CH_W-1:0]       ch_req,
    input  logic                  half_tick,
    input  logic                  frame_end,
    input  logic [FRAME_BITS-2:0] rx_word,
    output logic                  start,
    output logic [FRAME_BITS-1:0] tx_word,
    output logic                  busy,
    output logic                  adc_cs_n,
    output logic                  tmp_ce,
    output logic                  done,
    output logic [ADC_W-1:0]      adc_data,
    output logic [CH_W-1:0]       adc_ch,
    output logic [TEMP_W-1:0]     temp_data
);
    localparam int BW       = $clog2(DUMMY_FRAMES + 1);
    localparam int TEMP_TOP = FRAME_BITS - 2;

    seq_state_t   st;
    frame_kind_t  kind, launch_kind;
    logic [BW-1:0] boot_left;
    logic          gap_half, gap_done, launch;
    logic [CH_W-1:0] last_ch, req_ch;
    logic          last_valid;

    assign gap_done = (st == ST_GAP) && half_tick && gap_half;
    assign busy     = (st != ST_IDLE);
    assign adc_cs_n = !((st == ST_XFER) && (kind != KIND_TEMP));
    assign tmp_ce   = (st == ST_XFER) && (kind == KIND_TEMP);
    assign start    = launch;

    // Decide whether a frame begins this cycle and of which kind.
    always_comb begin
        launch      = 1'b0;
        launch_kind = kind;
        case (st)
            ST_IDLE: begin
                if (boot_left != '0) begin
                    launch      = 1'b1;
                    launch_kind = KIND_DUMMY;
                end else if (go) begin
                    launch = 1'b1;
                    if (sel_temp)
                        launch_kind = KIND_TEMP;
                    else if (!last_valid || (ch_req != last_ch))
                        launch_kind = KIND_WRITE;
                    else
                        launch_kind = KIND_READ;
                end
            end
            ST_GAP: begin
                if (gap_done && (kind == KIND_WRITE)) begin
                    launch      = 1'b1;
                    launch_kind = KIND_READ;
                end
            end
            default: ;
        endcase
    end

    // Form the outgoing control word for the frame being launched.
    always_comb begin
        tx_word = READ_WORD;
        case (launch_kind)
            KIND_DUMMY: tx_word = '1;
            KIND_WRITE: begin
                tx_word                 = CTRL_BASE;
                tx_word[FRAME_BITS-1]   = 1'b1;
                tx_word[CH_LSB +: CH_W] = ch_req;
            end
            default: tx_word = READ_WORD;
        endcase
    end

    // Advance the sequencer state and the startup frame count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind      <= KIND_DUMMY;
            gap_half  <= 1'b0;
            req_ch    <= '0;
            boot_left <= BW'(DUMMY_FRAMES);
        end else if (launch) begin
            st   <= ST_XFER;
            kind <= launch_kind;
            if ((st == ST_IDLE) && (launch_kind != KIND_TEMP))
                req_ch <= ch_req;
        end else begin
            case (st)
                ST_XFER: if (frame_end) begin
                    st       <= ST_GAP;
                    gap_half <= 1'b0;
                    if (kind == KIND_DUMMY) boot_left <= boot_left - 1'b1;
                end
                ST_GAP: if (half_tick) begin
                    if (gap_half) st <= ST_IDLE;
                    else          gap_half <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Latch results, remember the programmed channel, pulse completion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            adc_data   <= '0;
            adc_ch     <= '0;
            temp_data  <= '0;
            last_ch    <= '0;
            last_valid <= 1'b0;
        end else begin
            done <= 1'b0;
            if (frame_end) begin
                case (kind)
                    KIND_WRITE: begin
                        last_ch    <= req_ch;
                        last_valid <= 1'b1;
                    end
                    KIND_READ: begin
                        adc_data <= rx_word[ADC_W-1:0];
                        adc_ch   <= rx_word[ADC_W +: CH_W];
                        done     <= 1'b1;
                    end
                    KIND_TEMP: begin
                        temp_data <= rx_word[TEMP_TOP -: TEMP_W];
                        done      <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: never both devices selected.
    assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_cs_n && tmp_ce));

    // R8: completion is a single-cycle pulse.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion only follows a data frame.
    assert_done_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (kind == KIND_READ || kind == KIND_TEMP));

    // R2: no request frame while startup frames remain.
    assert_boot_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && kind != KIND_DUMMY) |-> (boot_left == '0));

    // R7: a read frame only runs once a channel has been programmed.
    assert_read_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && kind == KIND_READ) |-> last_valid);

endmodule

// File: rtl/sacq_top.sv
// Dual-sensor serial acquisition controller, top level.
// Joins the half-period timer, the frame shifter and the sequencer and
// drives the reset output. Assumes a single clock domain.
module sacq_top #(
    parameter int DIV_HALF   = 2,
    parameter int FRAME_BITS = 16,
    parameter int CH_W       = 3,
    parameter int ADC_W      = 12,
    parameter int TEMP_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              sel_temp,
    input  logic [CH_W-1:0]   ch_sel,
    input  logic              sdo,
    output logic              sclk,
    output logic              rst_out_n,
    output logic              sdi,
    output logic              adc_cs_n,
    output logic              tmp_ce,
    output logic              done,
    output logic [ADC_W-1:0]  adc_data,
    output logic [CH_W-1:0]   adc_ch,
    output logic [TEMP_W-1:0] temp_data
);
    logic                  half_tick, busy, start, frame_end;
    logic [FRAME_BITS-1:0] tx_word;
    logic [FRAME_BITS-2:0] rx_word;

    // Hold the reset output low while reset is applied.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_out_n <= 1'b0;
        else        rst_out_n <= 1'b1;
    end

    sacq_clkdiv #(.DIV_HALF(DIV_HALF)) clkdiv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .half_tick (half_tick)
    );

    sacq_shifter #(.FRAME_BITS(FRAME_BITS)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_word   (tx_word),
        .half_tick (half_tick),
        .sdo       (sdo),
        .sclk      (sclk),
        .sdi       (sdi),
        .rx_word   (rx_word),
        .frame_end (frame_end)
    );

    sacq_seq #(
        .FRAME_BITS (FRAME_BITS),
        .CH_W       (CH_W),
        .ADC_W      (ADC_W),
        .TEMP_W     (TEMP_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .sel_temp  (sel_temp),
        .ch_req    (ch_sel),
        .half_tick (half_tick),
        .frame_end (frame_end),
        .rx_word   (rx_word),
        .start     (start),
        .tx_word   (tx_word),
        .busy      (busy),
        .adc_cs_n  (adc_cs_n),
        .tmp_ce    (tmp_ce),
        .done      (done),
        .adc_data  (adc_data),
        .adc_ch    (adc_ch),
        .temp_data (temp_data)
    );

endmodule

// File: tb/sacq_top_tb_top.sv
// Bench: behavioural sensor models plus a per-clock protocol monitor and a
// behavioural model of the request policy.
module sacq_top_tb_top;
    localparam int BDIV     = 2;
    localparam int PERIOD   = 2 * BDIV;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic sel_temp = 1'b0;
    logic [2:0] ch_sel = 3'd0;
    logic sdo = 1'b1;
    logic sclk, rst_out_n, sdi, adc_cs_n, tmp_ce, done;
    logic [11:0] adc_data;
    logic [2:0]  adc_ch;
    logic [9:0]  temp_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sacq_top #(.DIV_HALF(BDIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .sel_temp(sel_temp),
        .ch_sel(ch_sel), .sdo(sdo), .sclk(sclk), .rst_out_n(rst_out_n),
        .sdi(sdi), .adc_cs_n(adc_cs_n), .tmp_ce(tmp_ce), .done(done),
        .adc_data(adc_data), .adc_ch(adc_ch), .temp_data(temp_data)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Frame record and sensor models.
    bit          rec_temp[$];
    logic [15:0] rec_word[$];
    logic [15:0] out_word = '0;
    logic [15:0] cap = '0;
    logic [15:0] last_adc_ret = '0;
    logic [15:0] last_tmp_ret = '0;
    logic [2:0]  dev_ctrl_ch = 3'd0;
    int adc_frames = 0, tmp_frames = 0, rise_cnt = 0, last_rise = 0;
    int idle_cnt = 1000, cycles = 0, done_count = 0;
    bit cs_prev = 0, sclk_prev = 1, sdi_prev = 1, done_prev = 0, cur_temp = 0;

    // Per-clock monitor and sensor behaviour, sampled on the falling clock.
    always @(negedge clk) begin
        bit cs_now;
        cycles++;
        if (cycles == WATCHDOG) begin
            check(0, "watchdog expired", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        cs_now = !adc_cs_n || tmp_ce;
        if (rst_n) begin
            check(!(!adc_cs_n && tmp_ce), "R4 both selects active", {adc_cs_n, tmp_ce}, 2'b10);
            if (!cs_now) check(sclk == 1'b1, "R3 sclk high when idle", sclk, 1);
            if (cs_now && !cs_prev) begin
                cur_temp = tmp_ce;
                if (tmp_ce) begin
                    logic [9:0] tv;
                    tv = 10'(10'h1C5 + tmp_frames * 37);
                    out_word = {1'b0, tv, 5'b0};
                end else begin
                    logic [11:0] av;
                    av = 12'(12'h5A3 + 12'(dev_ctrl_ch) * 12'h111 + adc_frames * 13);
                    out_word = {1'b0, dev_ctrl_ch, av};
                end
                sdo = out_word[15];
                rise_cnt = 0;
                cap = '0;
                check(idle_cnt >= PERIOD, "R11 gap between frames", idle_cnt, PERIOD);
            end
            if (cs_now && cs_prev) begin
                if (sclk && !sclk_prev) begin
                    cap = {cap[14:0], sdi};
                    if (rise_cnt > 0)
                        check(cycles - last_rise == PERIOD, "R3 serial clock period",
                              cycles - last_rise, PERIOD);
                    last_rise = cycles;
                    rise_cnt++;
                    if (rise_cnt < 16) sdo = out_word[15 - rise_cnt];
                end
                if (sdi != sdi_prev && !(sclk_prev && !sclk))
                    check(0, "R3 sdi moved without falling sclk", sdi, sdi_prev);
            end
            if (!cs_now && cs_prev) begin
                check(rise_cnt == 16, "R3 frame length", rise_cnt, 16);
                rec_temp.push_back(cur_temp);
                rec_word.push_back(cap);
                if (cur_temp) begin
                    last_tmp_ret = out_word;
                    tmp_frames++;
                end else begin
                    last_adc_ret = out_word;
                    if (adc_frames >= 2 && cap[15]) dev_ctrl_ch = cap[12:10];
                    adc_frames++;
                end
                idle_cnt = 0;
            end
            if (!cs_now) idle_cnt++;
            if (done) begin
                done_count++;
                if (done_prev) check(0, "R8 done wider than one clock", 2, 1);
            end
        end
        cs_prev = cs_now;
        sclk_prev = sclk;
        sdi_prev = sdi;
        done_prev = done;
    end

    // Behavioural model of the request policy.
    logic [2:0] m_last_ch = 3'd0;
    bit m_valid = 0;

    task automatic run_req(input bit temp, input logic [2:0] ch,
                           input bit collide, input string tag);
        int base, d0, n_exp;
        logic [11:0] adc_before;
        logic [2:0]  ch_before;
        bit want_wr;
        base = rec_word.size();
        d0 = done_count;
        adc_before = adc_data;
        ch_before = adc_ch;
        want_wr = !temp && (!m_valid || ch != m_last_ch);
        n_exp = (temp || !want_wr) ? 1 : 2;
        @(negedge clk);
        go = 1'b1; sel_temp = temp; ch_sel = ch;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        if (collide) begin
            go = 1'b1; sel_temp = 1'b0; ch_sel = ch ^ 3'd1;
            @(negedge clk);
            go = 1'b0;
        end
        repeat (120) @(negedge clk);
        check(done_count == d0 + 1, {tag, " R8 one done per request"}, done_count - d0, 1);
        check(rec_word.size() == base + n_exp, {tag, " R5/R6 frame count"},
              rec_word.size() - base, n_exp);
        if (rec_word.size() == base + n_exp) begin
            if (temp) begin
                check(rec_temp[base] == 1'b1, {tag, " R4 temp device selected"}, rec_temp[base], 1);
                check(temp_data == last_tmp_ret[14:5], {tag, " R9 temp result"},
                      temp_data, last_tmp_ret[14:5]);
                check(adc_data == adc_before && adc_ch == ch_before,
                      {tag, " R9 converter bus unchanged"}, adc_data, adc_before);
            end else begin
                if (want_wr) begin
                    logic [15:0] wexp;
                    wexp = 16'h8031 | ({13'd0, ch} << 10);
                    check(rec_temp[base] == 1'b0 && rec_word[base] == wexp,
                          {tag, " R5 write word"}, rec_word[base], wexp);
                end
                check(rec_temp[base + n_exp - 1] == 1'b0, {tag, " R4 converter selected"},
                      rec_temp[base + n_exp - 1], 0);
                check(rec_word[base + n_exp - 1] == 16'h0000, {tag, " R5 read word"},
                      rec_word[base + n_exp - 1], 0);
                check(adc_ch == ch, {tag, " R9 channel output"}, adc_ch, ch);
                check(adc_data == last_adc_ret[11:0], {tag, " R9 converter data"},
                      adc_data, last_adc_ret[11:0]);
            end
        end
        if (want_wr) begin
            m_valid = 1;
            m_last_ch = ch;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state.
        check(rst_out_n == 1'b0, "R1 reset output low", rst_out_n, 0);
        check(sclk == 1'b1 && adc_cs_n == 1'b1 && tmp_ce == 1'b0, "R1 bus idle",
              {sclk, adc_cs_n, tmp_ce}, 3'b110);
        check(done == 1'b0 && adc_data == '0 && adc_ch == '0 && temp_data == '0,
              "R1 outputs cleared", {done, adc_data, adc_ch, temp_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rst_out_n == 1'b1, "R1 reset output released", rst_out_n, 1);
        // R10: a request during the startup frames is dropped.
        repeat (8) @(negedge clk);
        go = 1'b1; sel_temp = 1'b0; ch_sel = 3'd5;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < 2000 && rec_word.size() < 2; i++) @(negedge clk);
        repeat (200) @(negedge clk);
        check(rec_word.size() == 2, "R10 request during startup ignored", rec_word.size(), 2);
        check(done_count == 0, "R2 no done for startup frames", done_count, 0);
        if (rec_word.size() >= 2) begin
            check(rec_word[0] == 16'hFFFF && rec_word[1] == 16'hFFFF,
                  "R2 startup control line high", rec_word[0], 16'hFFFF);
            check(rec_temp[0] == 1'b0 && rec_temp[1] == 1'b0,
                  "R2 startup frames to converter", {rec_temp[0], rec_temp[1]}, 0);
        end
        run_req(0, 3'd3, 0, "R7 first converter request");
        run_req(0, 3'd3, 0, "R6 same channel");
        run_req(0, 3'd6, 0, "R5 channel change");
        run_req(1, 3'd1, 0, "R4 R12 temperature request");
        run_req(0, 3'd6, 0, "R12 channel kept after temperature");
        run_req(0, 3'd2, 1, "R10 request on done cycle");
        run_req(1, 3'd7, 1, "R10 temp with collision");
        run_req(0, 3'd3, 0, "R5 change again");
        run_req(0, 3'd3, 0, "R6 repeat");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule